// File: doc/BRIEF.md
# Sleep-Time Wake Decision Unit

This unit decides when a battery-monitoring system that is asleep must be woken. Current and temperature results from the low-power measurement path arrive on two valid/ready streams. A single sample is compared against a current limit. A signed running sum of samples, which counts charge in both directions, is compared against a charge limit. Each temperature result is compared against a stored calibration temperature. Four event inputs are also watched: a timer request, a bus request, a wake pin that acts only on its rising edge, and the overflow of an internal lifetime counter.

Each source sets its own sticky status bit, and software clears that bit by writing 1 to it. The `wake` output is high while any status bit whose enable is also set is high. The temperature-drift source takes part in `wake` only while `low_power` is high. While `low_power` is low, that source drives `temp_irq` instead. A further status bit records that a wake has been signalled. Software sets thresholds, enables and the calibration temperature through a small register port. Both streams accept one sample on every cycle in which valid is high. Ready is tied high, so there is no back-pressure.

Register map (3-bit address, 32-bit data):

- 0: control. Bits 6:0 are the per-source enables. Bit 7 keeps the lifetime counter running while `low_power` is high.
- 1: status. Bits 6:0 are the source flags. Bit 7 is the woke flag. Writing 1 to a bit clears it.
- 2: current limit.
- 3: charge limit.
- 4: temperature delta.
- 5: calibration temperature. A write loads it.
- 6: a write of any value clears the charge sum.
- 7: charge sum, read only.

Source bit order in the status and enable fields: 0 current, 1 charge, 2 temperature drift, 3 lifetime overflow, 4 pin, 5 timer, 6 bus.

Top module: `lpw_top`

## Requirements
- R1: After reset, `wake` and `temp_irq` are 0, and the status and control registers read 0.
- R2: An accepted current sample whose magnitude is strictly greater than the current limit (register 2) sets status bit 0. A magnitude equal to the limit does not set it. Negative full scale counts as magnitude 32768.
- R3: Every accepted current sample is added, with its sign, to the charge sum (read at register 7). When the magnitude of the updated sum is strictly greater than the charge limit (register 3), status bit 1 is set. A write to register 6 clears the sum to 0.
- R4: An accepted temperature sample sets status bit 2 when |sample − calibration temperature| is strictly greater than the delta (register 4). While status bit 2 and its enable are set, the bit drives `temp_irq` (high, with `wake` low) when `low_power` is 0. When `low_power` is 1, the same bit drives `wake` (high, with `temp_irq` low).
- R5: The lifetime counter sets status bit 3 when it wraps. It always counts while `low_power` is 0. While `low_power` is 1, it counts only if control bit 7 is set.
- R6: Status bit 4 is set only by a 0-to-1 transition of `wake_pin`. A pin that stays high does not set the bit again after it is cleared.
- R7: A high `timer_wake` sets status bit 5, and a high `bus_wake` sets status bit 6.
- R8: Status bits stay set until a 1 is written to them at register 1. When a source event and a clear land in the same cycle, the bit remains set.
- R9: `wake` is the OR of the status bits whose enables are set. A source whose enable is clear still sets its status bit but does not raise `wake`.
- R10: Status bit 7 becomes set in the cycle after `wake` is high.
- R11: `cur_ready` and `tmp_ready` are always 1. Each cycle with valid high delivers exactly one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| low_power | input | 1 | 1 while the system is asleep |
| cur_valid | input | 1 | Current sample valid |
| cur_ready | output | 1 | Current sample ready (always 1) |
| cur_data | input | 16 | Signed current sample |
| tmp_valid | input | 1 | Temperature sample valid |
| tmp_ready | output | 1 | Temperature sample ready (always 1) |
| tmp_data | input | 16 | Signed temperature sample |
| timer_wake | input | 1 | Timer wake request |
| bus_wake | input | 1 | Bus wake request |
| wake_pin | input | 1 | Asynchronous wake pin, acts on its rising edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| wake | output | 1 | Wake request |
| temp_irq | output | 1 | Temperature-drift interrupt while awake |

## Verification
The properties assume that `timer_wake`, `bus_wake`, the stream valids and the register strobe are synchronous to `clk`. They also assume that `wake_pin` is slow enough for a level to survive the two-stage synchronizer. The bench therefore changes every input on the falling edge, and it holds the pin at each level for several cycles. The set-wins property also assumes that no other agent writes to register 1. The bench performs one register access at a time, and each access completes before the next stimulus begins.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  localparam int NSRC   = 7;
  localparam int ST_W   = NSRC + 1;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 32;

  localparam int SRC_CUR  = 0;
  localparam int SRC_CHG  = 1;
  localparam int SRC_TMP  = 2;
  localparam int SRC_LIFE = 3;
  localparam int SRC_PIN  = 4;
  localparam int SRC_TMR  = 5;
  localparam int SRC_BUS  = 6;
  localparam int ST_WOKE  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTHR = 3'd2;
  localparam logic [ADDR_W-1:0] A_QTHR = 3'd3;
  localparam logic [ADDR_W-1:0] A_TDLT = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAL  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACLR = 3'd6;
  localparam logic [ADDR_W-1:0] A_ACC  = 3'd7;
endpackage

// File: rtl/lpw_meas.sv
module lpw_meas #(
  parameter int SMP_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cur_valid,
  input  logic signed [SMP_W-1:0] cur_data,
  input  logic                    tmp_valid,
  input  logic signed [SMP_W-1:0] tmp_data,
  input  logic [SMP_W-1:0]        cur_thr,
  input  logic [ACC_W-1:0]        chg_thr,
  input  logic [SMP_W-1:0]        tmp_delta,
  input  logic signed [SMP_W-1:0] cal_temp,
  input  logic                    acc_clr,
  output logic                    cur_hit,
  output logic                    chg_hit,
  output logic                    tmp_hit,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [SMP_W:0] cur_ext, tdiff;
  logic signed [ACC_W:0] acc_ext;
  logic signed [ACC_W-1:0] acc_nxt;
  logic [SMP_W:0] cur_mag, tmp_mag;
  logic [ACC_W:0] acc_mag;

  // one extra bit keeps the magnitude of negative full scale exact
  always_comb begin
    cur_ext = (SMP_W+1)'(cur_data);
    cur_mag = cur_ext[SMP_W] ? (SMP_W+1)'(-cur_ext) : cur_ext;
    acc_nxt = acc + ACC_W'(cur_data);
    acc_ext = (ACC_W+1)'(acc_nxt);
    acc_mag = acc_ext[ACC_W] ? (ACC_W+1)'(-acc_ext) : acc_ext;
    tdiff   = (SMP_W+1)'(tmp_data) - (SMP_W+1)'(cal_temp);
    tmp_mag = tdiff[SMP_W] ? (SMP_W+1)'(-tdiff) : tdiff;
  end

  assign cur_hit = cur_valid && (cur_mag > {1'b0, cur_thr});
  assign chg_hit = cur_valid && (acc_mag > {1'b0, chg_thr});
  assign tmp_hit = tmp_valid && (tmp_mag > {1'b0, tmp_delta});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (acc_clr)   acc <= '0;
    else if (cur_valid) acc <= acc_nxt;
  end
endmodule

// File: rtl/lpw_lifetime.sv
module lpw_lifetime #(
  parameter int LT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ovf
);
  logic [LT_W-1:0] cnt;

  assign ovf = run && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpw_edge.sv
module lpw_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [SYNC_N-1:0] sync;
  logic              prev;

  assign rise = sync[SYNC_N-1] && !prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      prev <= 1'b0;
    end else begin
      sync <= {sync[SYNC_N-2:0], pin};
      prev <= sync[SYNC_N-1];
    end
  end
endmodule

// File: rtl/lpw_regs.sv
module lpw_regs
  import lpw_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  input  logic [NSRC-1:0]         hits,
  input  logic                    wake_in,
  input  logic signed [ACC_W-1:0] acc,
  output logic [NSRC-1:0]         en,
  output logic                    lt_lp_run,
  output logic [ST_W-1:0]         status,
  output logic [SMP_W-1:0]        cur_thr,
  output logic [ACC_W-1:0]        chg_thr,
  output logic [SMP_W-1:0]        tmp_delta,
  output logic signed [SMP_W-1:0] cal_temp,
  output logic                    acc_clr
);
  logic [ST_W-1:0] clr;

  assign acc_clr = we && (addr == A_ACLR);
  assign clr     = (we && addr == A_STAT) ? wdata[ST_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= '0;
      lt_lp_run <= 1'b0;
      status    <= '0;
      cur_thr   <= '0;
      chg_thr   <= '0;
      tmp_delta <= '0;
      cal_temp  <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_CTRL: begin
            en        <= wdata[NSRC-1:0];
            lt_lp_run <= wdata[NSRC];
          end
          A_CTHR:  cur_thr   <= wdata[SMP_W-1:0];
          A_QTHR:  chg_thr   <= wdata[ACC_W-1:0];
          A_TDLT:  tmp_delta <= wdata[SMP_W-1:0];
          A_CAL:   cal_temp  <= wdata[SMP_W-1:0];
          default: ;
        endcase
      end
      // a new event outranks a clear in the same cycle
      status <= (status & ~clr) | {wake_in, hits};
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = REG_W'({lt_lp_run, en});
      A_STAT:  rdata = REG_W'(status);
      A_CTHR:  rdata = REG_W'(cur_thr);
      A_QTHR:  rdata = REG_W'(chg_thr);
      A_TDLT:  rdata = REG_W'(tmp_delta);
      A_CAL:   rdata = REG_W'(cal_temp);
      A_ACC:   rdata = REG_W'(acc);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/lpw_top.sv
module lpw_top
  import lpw_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int ACC_W = 32,
  parameter int LT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               low_power,
  input  logic               cur_valid,
  output logic               cur_ready,
  input  logic [SMP_W-1:0]   cur_data,
  input  logic               tmp_valid,
  output logic               tmp_ready,
  input  logic [SMP_W-1:0]   tmp_data,
  input  logic               timer_wake,
  input  logic               bus_wake,
  input  logic               wake_pin,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               wake,
  output logic               temp_irq
);
  logic [NSRC-1:0]         en, hits, armed;
  logic [ST_W-1:0]         status;
  logic                    lt_lp_run, lt_ovf, pin_rise;
  logic                    cur_hit, chg_hit, tmp_hit, acc_clr;
  logic [SMP_W-1:0]        cur_thr, tmp_delta;
  logic [ACC_W-1:0]        chg_thr;
  logic signed [SMP_W-1:0] cal_temp;
  logic signed [ACC_W-1:0] acc;

  assign cur_ready = 1'b1;
  assign tmp_ready = 1'b1;

  lpw_meas #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_meas (
    .clk(clk), .rst_n(rst_n),
    .cur_valid(cur_valid), .cur_data($signed(cur_data)),
    .tmp_valid(tmp_valid), .tmp_data($signed(tmp_data)),
    .cur_thr(cur_thr), .chg_thr(chg_thr), .tmp_delta(tmp_delta),
    .cal_temp(cal_temp), .acc_clr(acc_clr),
    .cur_hit(cur_hit), .chg_hit(chg_hit), .tmp_hit(tmp_hit), .acc(acc)
  );

  lpw_lifetime #(.LT_W(LT_W)) u_life (
    .clk(clk), .rst_n(rst_n), .run(!low_power || lt_lp_run), .ovf(lt_ovf)
  );

  lpw_edge #(.SYNC_N(2)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(wake_pin), .rise(pin_rise)
  );

  always_comb begin
    hits           = '0;
    hits[SRC_CUR]  = cur_hit;
    hits[SRC_CHG]  = chg_hit;
    hits[SRC_TMP]  = tmp_hit;
    hits[SRC_LIFE] = lt_ovf;
    hits[SRC_PIN]  = pin_rise;
    hits[SRC_TMR]  = timer_wake;
    hits[SRC_BUS]  = bus_wake;
    armed          = en & status[NSRC-1:0];
    armed[SRC_TMP] = armed[SRC_TMP] & low_power;
  end

  assign wake     = |armed;
  assign temp_irq = en[SRC_TMP] && status[SRC_TMP] && !low_power;

  lpw_regs #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .hits(hits), .wake_in(wake), .acc(acc),
    .en(en), .lt_lp_run(lt_lp_run), .status(status),
    .cur_thr(cur_thr), .chg_thr(chg_thr), .tmp_delta(tmp_delta),
    .cal_temp(cal_temp), .acc_clr(acc_clr)
  );
endmodule

// File: rtl/lpw_checks.sv
module lpw_checks
  import lpw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cur_valid,
  input logic              tmp_valid,
  input logic              wake_pin,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              wake,
  input logic [NSRC-1:0]   en,
  input logic [ST_W-1:0]   status
);
  logic [ST_W-1:0] clr_mask;
  assign clr_mask = (reg_we && reg_addr == A_STAT) ? reg_wdata[ST_W-1:0] : '0;

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr_mask)) & ~status) == '0));

  // R9
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|(en & status[NSRC-1:0])));

  // R10
  woke_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> status[ST_WOKE]);

  // R2
  cur_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_CUR]) |-> $past(cur_valid));

  // R3
  chg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_CHG]) |-> $past(cur_valid));

  // R4
  tmp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_TMP]) |-> $past(tmp_valid));

  // R6
  pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_PIN]) |-> $past(wake_pin, 2));
endmodule

bind lpw_top lpw_checks i_chk (
  .clk(clk), .rst_n(rst_n), .cur_valid(cur_valid), .tmp_valid(tmp_valid),
  .wake_pin(wake_pin), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .wake(wake), .en(en), .status(status)
);

// File: tb/test_lpw_top.sv
module test_lpw_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic low_power = 1'b0;
  logic cur_valid = 1'b0, tmp_valid = 1'b0;
  logic [15:0] cur_data = '0, tmp_data = '0;
  logic timer_wake = 1'b0, bus_wake = 1'b0, wake_pin = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cur_ready, tmp_ready, wake, temp_irq;
  logic [31:0] rv;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  lpw_top #(.LT_W(4)) i_lpw_top (
    .clk(clk), .rst_n(rst_n), .low_power(low_power),
    .cur_valid(cur_valid), .cur_ready(cur_ready), .cur_data(cur_data),
    .tmp_valid(tmp_valid), .tmp_ready(tmp_ready), .tmp_data(tmp_data),
    .timer_wake(timer_wake), .bus_wake(bus_wake), .wake_pin(wake_pin),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake(wake), .temp_irq(temp_irq)
  );

  // sample, limit, expected status bit 0
  localparam logic [32:0] VEC [0:5] = '{
    {16'd50,    16'd40,     1'b1},
    {16'd40,    16'd40,     1'b0},
    {16'hFFD7,  16'd40,     1'b1},
    {16'hFFD8,  16'd40,     1'b0},
    {16'd0,     16'd0,      1'b0},
    {16'h8000,  16'h7FFF,   1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    reg_addr = a;
    #1 rv = reg_rdata;
  endtask

  task automatic send_cur(input logic [15:0] s);
    @(negedge clk);
    cur_valid = 1'b1; cur_data = s;
    @(negedge clk);
    cur_valid = 1'b0;
  endtask

  task automatic send_tmp(input logic [15:0] s);
    @(negedge clk);
    tmp_valid = 1'b1; tmp_data = s;
    @(negedge clk);
    tmp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd1); chk("R1 status", rv, 32'h0);
    rd(3'd0); chk("R1 ctrl", rv, 32'h0);
    chk("R1 wake", {31'b0, wake}, 32'h0);
    chk("R1 irq", {31'b0, temp_irq}, 32'h0);
    // R11 ready always high
    chk("R11 ready", {30'b0, cur_ready, tmp_ready}, 32'h3);

    // R2 table of current samples against the limit
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, {16'h0, VEC[i][16:1]});
      wr(3'd1, 32'hFF);
      send_cur(VEC[i][32:17]);
      rd(3'd1);
      chk($sformatf("R2 vec%0d", i), {31'b0, rv[0]}, {31'b0, VEC[i][0]});
    end

    // R3 charge sum
    wr(3'd6, 32'h0);
    rd(3'd7); chk("R3 cleared sum", rv, 32'h0);
    wr(3'd3, 32'd250);
    wr(3'd1, 32'hFF);
    send_cur(16'd100); send_cur(16'd100);
    rd(3'd1); chk("R3 below limit", {31'b0, rv[1]}, 32'h0);
    send_cur(16'd100);
    rd(3'd1); chk("R3 above limit", {31'b0, rv[1]}, 32'h1);
    rd(3'd7); chk("R3 sum", rv, 32'd300);
    wr(3'd6, 32'h0);
    wr(3'd1, 32'hFF);
    send_cur(16'hFED4);
    rd(3'd1); chk("R3 negative sum", {31'b0, rv[1]}, 32'h1);
    rd(3'd7); chk("R3 negative value", rv, 32'hFFFFFED4);

    // R4 temperature drift
    wr(3'd5, 32'd100);
    wr(3'd4, 32'd5);
    wr(3'd0, 32'h04);
    wr(3'd1, 32'hFF);
    send_tmp(16'd105);
    rd(3'd1); chk("R4 equal delta", {31'b0, rv[2]}, 32'h0);
    send_tmp(16'd106);
    rd(3'd1); chk("R4 drift up", {31'b0, rv[2]}, 32'h1);
    chk("R4 irq awake", {30'b0, temp_irq, wake}, 32'h2);
    @(negedge clk); low_power = 1'b1;
    #1 chk("R4 wake asleep", {30'b0, temp_irq, wake}, 32'h1);
    wr(3'd1, 32'hFF);
    send_tmp(16'd94);
    rd(3'd1); chk("R4 drift down", {31'b0, rv[2]}, 32'h1);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFF);

    // R5 lifetime counter
    low_power = 1'b0;
    wr(3'd1, 32'h08);
    repeat (20) @(negedge clk);
    rd(3'd1); chk("R5 awake wrap", {31'b0, rv[3]}, 32'h1);
    low_power = 1'b1;
    repeat (2) @(negedge clk);
    wr(3'd1, 32'h08);
    repeat (40) @(negedge clk);
    rd(3'd1); chk("R5 frozen asleep", {31'b0, rv[3]}, 32'h0);
    wr(3'd0, 32'h80);
    repeat (20) @(negedge clk);
    rd(3'd1); chk("R5 kept running", {31'b0, rv[3]}, 32'h1);
    wr(3'd0, 32'h0);

    // R6 wake pin
    wake_pin = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd1); chk("R6 rise", {31'b0, rv[4]}, 32'h1);
    wr(3'd1, 32'h10);
    repeat (5) @(negedge clk);
    rd(3'd1); chk("R6 held high", {31'b0, rv[4]}, 32'h0);
    wake_pin = 1'b0;
    repeat (4) @(negedge clk);
    wake_pin = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd1); chk("R6 second rise", {31'b0, rv[4]}, 32'h1);
    wake_pin = 1'b0;

    // R7 timer and bus
    wr(3'd1, 32'hFF);
    @(negedge clk); timer_wake = 1'b1;
    @(negedge clk); timer_wake = 1'b0;
    rd(3'd1); chk("R7 timer", {30'b0, rv[6:5]}, 32'h1);
    @(negedge clk); bus_wake = 1'b1;
    @(negedge clk); bus_wake = 1'b0;
    rd(3'd1); chk("R7 bus", {30'b0, rv[6:5]}, 32'h3);

    // R8 clear, and set wins over clear
    wr(3'd1, 32'h20);
    rd(3'd1); chk("R8 cleared", {31'b0, rv[5]}, 32'h0);
    rd(3'd1); chk("R8 other kept", {31'b0, rv[6]}, 32'h1);
    @(negedge clk); timer_wake = 1'b1;
    wr(3'd1, 32'h20);
    rd(3'd1); chk("R8 set wins", {31'b0, rv[5]}, 32'h1);
    @(negedge clk); timer_wake = 1'b0;

    // R9 and R10
    wr(3'd1, 32'hFF);
    @(negedge clk); bus_wake = 1'b1;
    @(negedge clk); bus_wake = 1'b0;
    #1 chk("R9 disabled source", {31'b0, wake}, 32'h0);
    rd(3'd1); chk("R9 status still set", {31'b0, rv[6]}, 32'h1);
    chk("R10 no woke yet", {31'b0, rv[7]}, 32'h0);
    wr(3'd0, 32'h40);
    #1 chk("R9 enabled wake", {31'b0, wake}, 32'h1);
    rd(3'd1); chk("R10 woke flag", {31'b0, rv[7]}, 32'h1);
    wr(3'd1, 32'hC0);
    #1 chk("R9 wake drops", {31'b0, wake}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule